// File: doc/BRIEF.md
# Two-Channel PCM Attenuator with Zero-Run Detection

This block scales a stereo PCM stream by a separate 8-bit volume code per channel. Each code step is worth about half a decibel. Code 0 silences the channel and code 255 passes the sample at unity gain. A common mute input pulls both channels down to silence. A per-channel invert input negates the scaled result. Volume changes never jump. The gain in use moves by one code per accepted sample until it reaches the requested code, so a large change becomes a short fade rather than a click.

Alongside the gain path, the block counts consecutive all-zero input samples on each channel. When a channel has received a long enough run of zeros it raises a flag. That flag clears on the first nonzero sample. Three configuration inputs shape how the flags reach the pins:
- whether detection is active at all,
- whether each pin reports its own channel or both pins report the AND of the two channels,
- whether the pin level is inverted.

Top module: `pcm_ch_attenuator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After reset, `out_valid`, `out_left` and `out_right` are 0. Both ramp codes are 0 and both zero-run counts are 0, so each zero pin equals `zd_invert`.
- R2: A ramp code of 0 produces an output of exactly 0. While `mute` is high, the ramp target of both channels is 0 whatever the volume codes are.
- R3: For a ramp code c from 1 to 255, let a = 255 - c. The gain is M[a mod 12] >> floor(a/12), a 16-bit unsigned value with 15 fraction bits. M is, for index 0 to 11: 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396.
- R4: Each accepted sample moves a channel's ramp code one step toward its target, which is the volume code or 0 under mute. The code does not move if it already equals the target. The sample is scaled with the code as it stands after this step.
- R5: The scaled value is floor((s*g + 16384) / 32768), where s is the signed 24-bit sample and g is the gain. It is saturated to the range -8388608 to 8388607.
- R6: When a channel's invert input is high as its sample is accepted, the rounded value is negated before saturation. For example, -8388608 at unity gain with invert gives 8388607.
- R7: A sample presented with `in_valid` high at a rising edge appears on the outputs after the following rising edge. `out_valid` is high for exactly that one cycle per accepted sample.
- R8: A channel's zero flag is set once that channel has accepted ZERO_RUN (8192) consecutive samples equal to 0. It clears when the channel accepts a nonzero sample. The pin shows the change right after the edge that accepts the sample.
- R9: When `zd_enable` is low, both raw flags read 0. When `zd_and_mode` is high, both pins report the AND of the two channel flags.
- R10: When `zd_invert` is high, both zero pins show the complement of their raw flag.
- R11: Clock cycles with `in_valid` low change nothing. The ramp codes do not step, the zero-run counts neither advance nor reset, and no output sample is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample pair present this cycle |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_left | input | 8 | Left volume code (0 silent, 255 unity) |
| vol_right | input | 8 | Right volume code |
| inv_left | input | 1 | Negate left output |
| inv_right | input | 1 | Negate right output |
| mute | input | 1 | Drive both ramp targets to 0 |
| zd_enable | input | 1 | Zero detection active |
| zd_and_mode | input | 1 | Both pins report the AND of the two flags |
| zd_invert | input | 1 | Invert the zero pin level |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | 24 | Left scaled sample |
| out_right | output | 24 | Right scaled sample |
| zero_left | output | 1 | Left zero-run pin |
| zero_right | output | 1 | Right zero-run pin |

## Verification
The bench drives inputs a little after a rising edge and checks 2 ns after the next one.

The two results are due at different times:
- **Zero pins.** They already reflect the sample just accepted, together with whatever configuration is present at that moment. They are compared against the model's run counts in the same check.
- **Data outputs.** They carry the sample accepted one step earlier. The bench therefore keeps one step of expected data, built from its own ramp, gain and rounding model, and compares it with `out_valid` and both channels at each check.

Idle cycles push nothing into that one-step pipeline. A gap is therefore seen as `out_valid` low, and the held run counts show up as a zero flag that appears exactly one sample after the gap.

// File: rtl/att_pkg.sv
// Package: shared widths and the volume-code to gain mapping.
// Assumes 8-bit codes with 0.5 dB per code; 12 codes per ~6 dB octave.
package att_pkg;
    localparam int DW        = 24;  // sample width
    localparam int CODE_W    = 8;   // volume code width
    localparam int GAIN_W    = 16;  // unsigned gain width
    localparam int GAIN_FRAC = 15;  // fraction bits of gain
    localparam int STEPS_OCT = 12;  // codes per halving of gain

    // Gain for a code: octave mantissa shifted right by the octave count.
    function automatic logic [GAIN_W-1:0] gain_of(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] atten;
        logic [GAIN_W-1:0] mant;
        int                octave;
        atten  = CODE_W'((1 << CODE_W) - 1) - code;
        octave = int'(atten) / STEPS_OCT;
        case (int'(atten) % STEPS_OCT)
            0:       mant = 16'd32768;
            1:       mant = 16'd30935;
            2:       mant = 16'd29205;
            3:       mant = 16'd27571;
            4:       mant = 16'd26029;
            5:       mant = 16'd24573;
            6:       mant = 16'd23198;
            7:       mant = 16'd21900;
            8:       mant = 16'd20675;
            9:       mant = 16'd19519;
            10:      mant = 16'd18427;
            default: mant = 16'd17396;
        endcase
        if (code == '0) return '0;
        return mant >> octave;
    endfunction
endpackage

// File: rtl/att_ramp.sv
// Volume ramp: the applied code walks one step per accepted sample toward
// the target. Assumes target may change on any cycle; reset starts silent.
module att_ramp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] target,
    output logic [CW-1:0] code_next
);
    logic [CW-1:0] code_q;
    logic [CW-1:0] moved;

    // Purpose: one code toward the target, or stay when equal.
    always_comb begin
        if (code_q < target)      moved = code_q + 1'b1;
        else if (code_q > target) moved = code_q - 1'b1;
        else                      moved = code_q;
    end

    assign code_next = step ? moved : code_q;

    // Purpose: hold the applied code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_next;
    end

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ({1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1) ||
                 ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)}) ||
                 (code_q == $past(code_q)));

    a_r4_moves_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (step && code_q != target) |=> !$stable(code_q));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(code_q));
endmodule

// File: rtl/att_scale.sv
// Scaler: registers sample and gain, then multiplies, rounds half up,
// optionally negates and saturates. Two register stages from input to output.
module att_scale
    import att_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DW-1:0]     sample,
    input  logic        [GAIN_W-1:0] gain,
    input  logic                     invert,
    output logic                     out_vld,
    output logic signed [DW-1:0]     out_smp
);
    localparam int PW = DW + GAIN_W + 1;
    localparam logic signed [PW-1:0] MAXV = PW'(2 ** (DW - 1) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - 1;
    localparam logic signed [PW-1:0] HALF = PW'(2 ** (GAIN_FRAC - 1));

    logic signed [DW-1:0]     s_q;
    logic        [GAIN_W-1:0] g_q;
    logic                     inv_q;
    logic                     v_q;
    logic signed [PW-1:0]     prod, shf, sgn;
    logic signed [DW-1:0]     sat;

    // Purpose: capture operands of an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0; g_q <= '0; inv_q <= 1'b0; v_q <= 1'b0;
        end else begin
            v_q <= in_vld;
            if (in_vld) begin
                s_q <= sample; g_q <= gain; inv_q <= invert;
            end
        end
    end

    // Purpose: multiply, round, negate, clamp.
    always_comb begin
        prod = PW'(s_q) * PW'($signed({1'b0, g_q}));
        shf  = (prod + HALF) >>> GAIN_FRAC;
        sgn  = inv_q ? -shf : shf;
        if (sgn > MAXV)      sat = MAXV[DW-1:0];
        else if (sgn < MINV) sat = MINV[DW-1:0];
        else                 sat = sgn[DW-1:0];
    end

    // Purpose: output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0; out_smp <= '0;
        end else begin
            out_vld <= v_q;
            if (v_q) out_smp <= sat;
        end
    end

    a_r2_zero_gain_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && g_q == '0) |=> (out_smp == '0));

    a_r6_invert_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && inv_q && s_q == MINV[DW-1:0] && g_q == GAIN_W'(2 ** GAIN_FRAC))
        |=> (out_smp == MAXV[DW-1:0]));
endmodule

// File: rtl/att_zero_watch.sv
// Zero-run watcher: counts consecutive accepted zero samples, saturating at
// RUN; flag is high while the count has reached RUN. Idle cycles hold count.
module att_zero_watch #(
    parameter int DWID = 24,
    parameter int RUN  = 8192
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [DWID-1:0] sample,
    output logic            flag
);
    localparam int CNT_W = $clog2(RUN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance on zero, restart on data, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (in_vld) begin
            if (sample != '0)        cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flag = (cnt_q == LIMIT);

    a_r8_clear_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sample != '0) |=> !flag);

    a_r11_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(cnt_q));
endmodule

// File: rtl/pcm_ch_attenuator.sv
// Top: two channels of ramped attenuation with invert, common mute, and
// zero-run flags routed through enable, AND-combine and polarity controls.
module pcm_ch_attenuator
    import att_pkg::*;
#(
    parameter int ZERO_RUN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_left,
    input  logic [DW-1:0]     in_right,
    input  logic [CODE_W-1:0] vol_left,
    input  logic [CODE_W-1:0] vol_right,
    input  logic              inv_left,
    input  logic              inv_right,
    input  logic              mute,
    input  logic              zd_enable,
    input  logic              zd_and_mode,
    input  logic              zd_invert,
    output logic              out_valid,
    output logic [DW-1:0]     out_left,
    output logic [DW-1:0]     out_right,
    output logic              zero_left,
    output logic              zero_right
);
    localparam int NCH = 2;

    logic [NCH-1:0][DW-1:0]     ch_in;
    logic [NCH-1:0][CODE_W-1:0] ch_vol;
    logic [NCH-1:0]             ch_inv;
    logic [NCH-1:0][DW-1:0]     ch_out;
    logic [NCH-1:0]             ch_vld;
    logic [NCH-1:0]             ch_flag;
    logic [NCH-1:0]             raw;

    assign ch_in  = {in_right, in_left};
    assign ch_vol = {vol_right, vol_left};
    assign ch_inv = {inv_right, inv_left};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CODE_W-1:0] code_next;
        logic [CODE_W-1:0] target;

        assign target = mute ? '0 : ch_vol[c];

        att_ramp #(.CW(CODE_W)) i_ramp (
            .clk(clk), .rst_n(rst_n), .step(in_valid),
            .target(target), .code_next(code_next)
        );

        att_scale i_scale (
            .clk(clk), .rst_n(rst_n), .in_vld(in_valid),
            .sample($signed(ch_in[c])), .gain(gain_of(code_next)),
            .invert(ch_inv[c]), .out_vld(ch_vld[c]), .out_smp(ch_out[c])
        );

        att_zero_watch #(.DWID(DW), .RUN(ZERO_RUN)) i_zero (
            .clk(clk), .rst_n(rst_n), .in_vld(in_valid),
            .sample(ch_in[c]), .flag(ch_flag[c])
        );
    end

    // Purpose: route flags through enable, AND-combine and polarity.
    always_comb begin
        if (!zd_enable)      raw = '0;
        else if (zd_and_mode) raw = {NCH{&ch_flag}};
        else                 raw = ch_flag;
    end

    assign zero_left  = raw[0] ^ zd_invert;
    assign zero_right = raw[1] ^ zd_invert;
    assign out_valid  = &ch_vld;
    assign out_left   = ch_out[0];
    assign out_right  = ch_out[1];

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
endmodule

// File: tb/test_pcm_attenuator.sv
module test_pcm_attenuator;
    localparam int ZL = 8192;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [23:0] in_left, in_right;
    logic [7:0]  vol_left, vol_right;
    logic        inv_left, inv_right, mute;
    logic        zd_enable, zd_and_mode, zd_invert;
    logic        out_valid;
    logic [23:0] out_left, out_right;
    logic        zero_left, zero_right;

    always #5 clk = ~clk;

    pcm_ch_attenuator #(.ZERO_RUN(ZL)) i_pcm_ch_attenuator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .vol_left(vol_left), .vol_right(vol_right),
        .inv_left(inv_left), .inv_right(inv_right), .mute(mute),
        .zd_enable(zd_enable), .zd_and_mode(zd_and_mode), .zd_invert(zd_invert),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .zero_left(zero_left), .zero_right(zero_right)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    int     cur_l = 0, cur_r = 0;
    int     zc_l = 0, zc_r = 0;
    bit     pv = 1'b0;
    longint pl = 0, pr = 0;

    // R3 mantissa list as stated in the requirement
    function automatic longint gain_ref(int code);
        longint m;
        int a;
        if (code == 0) return 0;
        a = 255 - code;
        case (a % 12)
            0: m = 32768;  1: m = 30935;  2: m = 29205;  3: m = 27571;
            4: m = 26029;  5: m = 24573;  6: m = 23198;  7: m = 21900;
            8: m = 20675;  9: m = 19519;  10: m = 18427; default: m = 17396;
        endcase
        return m >> (a / 12);
    endfunction

    // R5 rounding and R6 negation with clamp
    function automatic longint scale_ref(longint s, int code, bit inv);
        longint p, r;
        p = s * gain_ref(code);
        r = (p + 16384) >>> 15;
        if (inv) r = -r;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    function automatic int ramp_ref(int cur, int tgt);
        if (cur < tgt) return cur + 1;
        if (cur > tgt) return cur - 1;
        return cur;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, advance the model, check after the next rising edge.
    task automatic step(bit v, longint l, longint r);
        longint el, er;
        bit fl, fr, rl, rr;
        el = 0; er = 0;
        in_valid = v;
        in_left  = l[23:0];
        in_right = r[23:0];
        if (v) begin
            cur_l = ramp_ref(cur_l, mute ? 0 : int'(vol_left));   // R4
            cur_r = ramp_ref(cur_r, mute ? 0 : int'(vol_right));  // R2 mute target
            el = scale_ref(l, cur_l, inv_left);
            er = scale_ref(r, cur_r, inv_right);
            zc_l = (l[23:0] == 0) ? ((zc_l < ZL) ? zc_l + 1 : ZL) : 0;
            zc_r = (r[23:0] == 0) ? ((zc_r < ZL) ? zc_r + 1 : ZL) : 0;
        end
        @(posedge clk);
        #2;
        chk("R7 out_valid", longint'(out_valid), longint'(pv));
        if (pv) begin
            chk("R3 R4 R5 R6 left data", longint'($signed(out_left)), pl);
            chk("R3 R4 R5 R6 right data", longint'($signed(out_right)), pr);
        end
        fl = (zc_l >= ZL);
        fr = (zc_r >= ZL);
        rl = zd_enable ? (zd_and_mode ? (fl & fr) : fl) : 1'b0;   // R9
        rr = zd_enable ? (zd_and_mode ? (fl & fr) : fr) : 1'b0;
        chk("R8 R9 R10 zero_left", longint'(zero_left), longint'(rl ^ zd_invert));
        chk("R8 R9 R10 zero_right", longint'(zero_right), longint'(rr ^ zd_invert));
        pv = v; pl = el; pr = er;
    endtask

    function automatic longint rnd_sample();
        int unsigned k;
        k = $urandom % 16;
        if (k == 0) return -8388608;
        if (k == 1) return 8388607;
        if (k == 2) return 0;
        return longint'($signed(24'($urandom)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
        vol_left = 8'd255; vol_right = 8'd255;
        inv_left = 1'b0; inv_right = 1'b0; mute = 1'b0;
        zd_enable = 1'b1; zd_and_mode = 1'b0; zd_invert = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state, pins follow zd_invert
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_left", longint'(out_left), 0);
        chk("R1 out_right", longint'(out_right), 0);
        chk("R1 zero_left", longint'(zero_left), 1);
        chk("R1 zero_right", longint'(zero_right), 1);
        zd_invert = 1'b0;
        rst_n = 1'b1;

        // R4: ramp up from silence toward 255
        for (int i = 0; i < 300; i++) step(1'b1, 1000000, -777777);

        // Random phase with volume, invert, mute changes and idle gaps (R11)
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 64 == 0)  vol_left  = 8'($urandom);
            if ($urandom % 64 == 0)  vol_right = 8'($urandom);
            if ($urandom % 128 == 0) inv_left  = ~inv_left;
            if ($urandom % 128 == 0) inv_right = ~inv_right;
            if ($urandom % 256 == 0) mute      = ~mute;
            step(($urandom % 4) != 0, rnd_sample(), rnd_sample());
        end

        // R2: mute drives output to exactly 0 once ramped down
        mute = 1'b1;
        for (int i = 0; i < 300; i++) step(1'b1, 4000000, -4000000);
        step(1'b1, 8388607, -8388608);
        step(1'b0, 0, 0);
        chk("R2 muted left", longint'(out_left), 0);
        mute = 1'b0;

        // R6: full-scale negative at unity with invert clamps
        vol_left = 8'd255; vol_right = 8'd255; inv_left = 1'b1; inv_right = 1'b0;
        for (int i = 0; i < 300; i++) step(1'b1, 12345, -12345);
        step(1'b1, -8388608, -8388608);
        step(1'b0, 0, 0);
        chk("R6 invert clamp", longint'($signed(out_left)), 8388607);
        chk("R5 unity pass", longint'($signed(out_right)), -8388608);
        inv_left = 1'b0;

        // R8 and R11: zero run with an idle gap of nonzero data
        zd_enable = 1'b1; zd_and_mode = 1'b0; zd_invert = 1'b0;
        for (int i = 0; i < ZL - 1; i++) step(1'b1, 0, 5);
        for (int i = 0; i < 10; i++) step(1'b0, 123, 5);
        chk("R11 gap ignored", longint'(zero_left), 0);
        step(1'b1, 0, 5);
        chk("R8 flag set", longint'(zero_left), 1);
        chk("R8 other channel", longint'(zero_right), 0);

        // R9: AND mode
        zd_and_mode = 1'b1;
        step(1'b1, 0, 5);
        chk("R9 and mode one flag", longint'(zero_left), 0);
        for (int i = 0; i < ZL; i++) step(1'b1, 0, 0);
        chk("R9 and mode both", longint'(zero_right), 1);

        // R10: polarity, then R9 enable off
        zd_invert = 1'b1;
        step(1'b1, 0, 0);
        chk("R10 inverted pin", longint'(zero_left), 0);
        zd_enable = 1'b0;
        step(1'b1, 0, 0);
        chk("R9 disabled raw", longint'(zero_left), 1);

        // R8: clear on first nonzero sample
        zd_enable = 1'b1; zd_and_mode = 1'b0; zd_invert = 1'b0;
        step(1'b1, 7, 0);
        chk("R8 cleared", longint'(zero_left), 0);
        chk("R8 still set", longint'(zero_right), 1);
        step(1'b0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule